// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the controller-side sender of a time-division serial audio link. It runs from the bit clock that the codec supplies and counts that clock into frames of 256 bit times. From the count it produces the frame sync and a single serial data line. Each frame opens with a 16-bit tag slot, followed by twelve 20-bit payload slots. The tag slot says which payload slots carry data. A payload slot holds 16 meaningful bits at its top, and all of its other bits are zero.

The user presents a per-slot valid mask, a command word for slot 1, a write-data word for slot 2 and ten 16-bit samples for slots 3 to 12. All of these are sampled together at the clock edge that begins a frame. A one-cycle strobe marks that edge. After the strobe the user may set up the next frame's values without disturbing the frame in flight. At 12.288 MHz the frame rate is 48 kHz.

Top module: `acl_link_tx`

## Requirements
- R1: While rst_n is sampled low, sync_o, sdo_o and frame_ld_o are driven low at the next edge. The first rising edge with rst_n high starts a frame, so sync_o and frame_ld_o are high in the following cycle.
- R2: sync_o is high for exactly 16 consecutive cycles and then low for exactly 240 cycles, repeating with a 256-cycle period.
- R3: All parallel inputs are sampled at the edge that raises sync_o. frame_ld_o is high in that one cycle only. Input changes made after that edge have no effect on the frame being sent.
- R4: sdo_o is low in the first sync-high cycle. Frame bit k (k = 0 to 255, in transmit order) is on sdo_o in the cycle k+1 cycles after sync_o rises.
- R5: Frame bits 0 to 15 carry the tag word MSB first. Tag bit 15 is the OR of slot_vld_i. Tag bits 14 down to 3 are slot_vld_i[0] up to slot_vld_i[11], so bit 14 belongs to slot 1 and bit 3 to slot 12. Tag bits 2:0 are zero.
- R6: Slot s (1 to 12) occupies frame bits 16+20(s-1) to 35+20(s-1), MSB first. When slot 1 is valid, its bit 19 is cmd_rd_i (1 = read), bits 18:12 are cmd_addr_i and bits 11:0 are zero.
- R7: When slot 2 is valid, its bits 19:4 are cmd_wdata_i and bits 3:0 are zero.
- R8: When slot s in 3 to 12 is valid, its bits 19:4 are pcm_i[(s-3)*16 +: 16] and bits 3:0 are zero.
- R9: Every bit of a slot whose slot_vld_i bit is 0 is zero, whatever the data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock from the codec; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_vld_i | input | 12 | Valid mask; bit i marks slot i+1 |
| cmd_rd_i | input | 1 | Slot 1 command flag, 1 = read |
| cmd_addr_i | input | 7 | Slot 1 register address |
| cmd_wdata_i | input | 16 | Slot 2 write data |
| pcm_i | input | 160 | Samples for slots 3 to 12, slot s at bits (s-3)*16 +: 16 |
| sync_o | output | 1 | Frame sync, high during the tag phase |
| sdo_o | output | 1 | Serial frame data, MSB first |
| frame_ld_o | output | 1 | One-cycle strobe: inputs were sampled for the frame now starting |

## Verification
A frame counter that slips by even one position shows up at the ports at once. The sync pulse takes the wrong length or period within one frame, and every later field lands one bit early or late. A corrupt slot index or bit index sends a payload into the wrong slot, or breaks the zero stuffing of the four trailing bits. That error appears in the same frame, within 20 bit times of the fault. A capture register that loads at the wrong time is only seen once the inputs have changed after the strobe, so the bench scrambles every input right after each strobe.

// File: rtl/acl_pkg.sv
// Package: acl_pkg
// Default frame geometry for the serial audio link transmitter. The
// modules take these values as parameter defaults and derive every
// count and width from them.
package acl_pkg;
    localparam int ACL_SLOTS  = 12;  // payload slots per frame
    localparam int ACL_SLOT_W = 20;  // bit times per payload slot
    localparam int ACL_TAG_W  = 16;  // bit times in the tag slot
    localparam int ACL_DATA_W = 16;  // meaningful bits per payload slot
    localparam int ACL_ADDR_W = 7;   // command address width in slot 1
endpackage

// File: rtl/acl_frame_timer.sv
// Module: acl_frame_timer
// Counts bit-clock cycles through one frame. It reports the frame
// position (segment and bit within segment) of the bit that the
// serializer drives at the coming edge, and it registers the frame sync.
// Assumes TAG_W and SLOT_W each fit in the bit-index width. Sync is
// computed one position ahead, so that it leads the data by one bit time.
module acl_frame_timer #(
    parameter int SLOTS  = acl_pkg::ACL_SLOTS,
    parameter int SLOT_W = acl_pkg::ACL_SLOT_W,
    parameter int TAG_W  = acl_pkg::ACL_TAG_W,
    localparam int FRAME_LEN = TAG_W + SLOTS * SLOT_W,
    localparam int POS_W     = $clog2(FRAME_LEN),
    localparam int SEG_W     = $clog2(SLOTS + 1),
    localparam int BIT_W     = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             frame_start_o,
    output logic [SEG_W-1:0] seg_o,
    output logic [BIT_W-1:0] bix_o,
    output logic             sync_o
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] SYNC_END = POS_W'(TAG_W - 1);
    localparam logic [BIT_W-1:0] TAG_END  = BIT_W'(TAG_W - 1);
    localparam logic [BIT_W-1:0] SLOT_END = BIT_W'(SLOT_W - 1);

    logic [POS_W-1:0] pos_q;
    logic [SEG_W-1:0] seg_q;
    logic [BIT_W-1:0] bix_q;
    logic             sync_q;
    logic             seg_end;

    // The last bit of the current segment is at the next edge
    always_comb begin
        if (seg_q == '0) seg_end = (bix_q == TAG_END);
        else             seg_end = (bix_q == SLOT_END);
    end

    assign frame_start_o = (pos_q == POS_LAST);

    // Advance the frame position; reset parks on the last bit so the first edge opens a frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_LAST;
            seg_q <= SEG_W'(SLOTS);
            bix_q <= SLOT_END;
        end else if (frame_start_o) begin
            pos_q <= '0;
            seg_q <= '0;
            bix_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
            if (seg_end) begin
                seg_q <= seg_q + 1'b1;
                bix_q <= '0;
            end else begin
                bix_q <= bix_q + 1'b1;
            end
        end
    end

    // Sync is high for the tag phase, raised one bit time before tag bit 15 is driven
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= frame_start_o || (pos_q < SYNC_END);
    end

    assign seg_o  = seg_q;
    assign bix_o  = bix_q;
    assign sync_o = sync_q;
endmodule

// File: rtl/acl_slot_mux.sv
// Module: acl_slot_mux
// Forms the tag word and one padded word per payload slot from the
// captured frame inputs, then selects the single bit named by the frame
// position. Assumes TAG_W >= SLOTS + 1 and SLOT_W >= 1 + ADDR_W.
// Invalid slots are forced to all zeros here.
module acl_slot_mux #(
    parameter int SLOTS  = acl_pkg::ACL_SLOTS,
    parameter int SLOT_W = acl_pkg::ACL_SLOT_W,
    parameter int TAG_W  = acl_pkg::ACL_TAG_W,
    parameter int DATA_W = acl_pkg::ACL_DATA_W,
    parameter int ADDR_W = acl_pkg::ACL_ADDR_W,
    localparam int SEG_W = $clog2(SLOTS + 1),
    localparam int BIT_W = $clog2(SLOT_W),
    localparam int PCM_W = (SLOTS - 2) * DATA_W
) (
    input  logic [SLOTS-1:0]  vld_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PCM_W-1:0]  pcm_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [BIT_W-1:0]  bix_i,
    output logic              bit_o
);
    logic [TAG_W-1:0]  tag_w;
    logic [SLOT_W-1:0] words [SLOTS+1];
    logic [SLOT_W-1:0] cur_w;
    logic [BIT_W-1:0]  bit_sel;

    // Tag word: frame-valid flag, then one flag per slot in slot order, zero below
    always_comb begin
        tag_w = '0;
        tag_w[TAG_W-1] = |vld_i;
        for (int s = 1; s <= SLOTS; s++) begin
            tag_w[TAG_W-1-s] = vld_i[s-1];
        end
    end

    assign words[0] = {tag_w, {(SLOT_W - TAG_W){1'b0}}};

    genvar g;
    generate
        for (g = 1; g <= SLOTS; g++) begin : g_slot
            if (g == 1) begin : g_cmd
                assign words[g] = vld_i[g-1]
                    ? {rd_i, addr_i, {(SLOT_W - 1 - ADDR_W){1'b0}}} : '0;
            end else if (g == 2) begin : g_wdata
                assign words[g] = vld_i[g-1]
                    ? {wdata_i, {(SLOT_W - DATA_W){1'b0}}} : '0;
            end else begin : g_pcm
                assign words[g] = vld_i[g-1]
                    ? {pcm_i[(g-3)*DATA_W +: DATA_W], {(SLOT_W - DATA_W){1'b0}}} : '0;
            end
        end
    endgenerate

    // Pick the word of the current segment
    always_comb begin
        cur_w = '0;
        for (int i = 0; i <= SLOTS; i++) begin
            if (seg_i == SEG_W'(i)) cur_w = words[i];
        end
    end

    // Bits leave MSB first within every segment
    assign bit_sel = BIT_W'(SLOT_W - 1) - bix_i;
    assign bit_o   = cur_w[bit_sel];
endmodule

// File: rtl/acl_link_tx.sv
// Module: acl_link_tx
// Top of the serial audio link frame transmitter. It samples all
// parallel inputs at the edge that opens a frame, strobes frame_ld_o for
// that one cycle, and drives the registered serial data one bit time
// behind sync. Assumes the user holds its inputs steady across the
// frame-opening edge, and changes them only after the strobe.
module acl_link_tx #(
    parameter int SLOTS  = acl_pkg::ACL_SLOTS,
    parameter int SLOT_W = acl_pkg::ACL_SLOT_W,
    parameter int TAG_W  = acl_pkg::ACL_TAG_W,
    parameter int DATA_W = acl_pkg::ACL_DATA_W,
    parameter int ADDR_W = acl_pkg::ACL_ADDR_W,
    localparam int PCM_W = (SLOTS - 2) * DATA_W,
    localparam int SEG_W = $clog2(SLOTS + 1),
    localparam int BIT_W = $clog2(SLOT_W)
) (
    input  logic              clk_bit,
    input  logic              rst_n,
    input  logic [SLOTS-1:0]  slot_vld_i,
    input  logic              cmd_rd_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    input  logic [PCM_W-1:0]  pcm_i,
    output logic              sync_o,
    output logic              sdo_o,
    output logic              frame_ld_o
);
    logic             frame_start;
    logic [SEG_W-1:0] seg;
    logic [BIT_W-1:0] bix;
    logic             next_bit;

    logic [SLOTS-1:0]  vld_q;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [PCM_W-1:0]  pcm_q;
    logic              ld_q;
    logic              sdo_q;

    acl_frame_timer #(
        .SLOTS (SLOTS),
        .SLOT_W(SLOT_W),
        .TAG_W (TAG_W)
    ) u_timer (
        .clk          (clk_bit),
        .rst_n        (rst_n),
        .frame_start_o(frame_start),
        .seg_o        (seg),
        .bix_o        (bix),
        .sync_o       (sync_o)
    );

    // Sample every frame input together at the frame-opening edge
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            vld_q   <= '0;
            rd_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            pcm_q   <= '0;
        end else if (frame_start) begin
            vld_q   <= slot_vld_i;
            rd_q    <= cmd_rd_i;
            addr_q  <= cmd_addr_i;
            wdata_q <= cmd_wdata_i;
            pcm_q   <= pcm_i;
        end
    end

    // Tell the user the inputs have been taken for the frame now starting
    always_ff @(posedge clk_bit) begin
        if (!rst_n) ld_q <= 1'b0;
        else        ld_q <= frame_start;
    end

    acl_slot_mux #(
        .SLOTS (SLOTS),
        .SLOT_W(SLOT_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_mux (
        .vld_i  (vld_q),
        .rd_i   (rd_q),
        .addr_i (addr_q),
        .wdata_i(wdata_q),
        .pcm_i  (pcm_q),
        .seg_i  (seg),
        .bix_i  (bix),
        .bit_o  (next_bit)
    );

    // Register the serial line so that it changes only on the rising edge
    always_ff @(posedge clk_bit) begin
        if (!rst_n) sdo_q <= 1'b0;
        else        sdo_q <= next_bit;
    end

    assign sdo_o      = sdo_q;
    assign frame_ld_o = ld_q;
endmodule

// File: rtl/acl_link_tx_chk.sv
// Module: acl_link_tx_chk
// Port-level protocol checker for acl_link_tx, bound to every instance.
// It times the sync pulse and tracks the offset since sync rose, so that
// it can check the zero-stuffed bit times of each frame.
module acl_link_tx_chk #(
    parameter int SLOTS  = acl_pkg::ACL_SLOTS,
    parameter int SLOT_W = acl_pkg::ACL_SLOT_W,
    parameter int TAG_W  = acl_pkg::ACL_TAG_W,
    parameter int DATA_W = acl_pkg::ACL_DATA_W
) (
    input logic clk_bit,
    input logic rst_n,
    input logic sync_o,
    input logic sdo_o,
    input logic frame_ld_o
);
    localparam int FRAME_LEN = TAG_W + SLOTS * SLOT_W;
    localparam int CNT_W     = $clog2(FRAME_LEN) + 2;

    logic             sync_d;
    logic             started;
    logic             seen_fall;
    logic [CNT_W-1:0] ofs_q;
    logic [CNT_W-1:0] ofs_now;
    logic [CNT_W-1:0] hi_run;
    logic [CNT_W-1:0] lo_run;
    logic             in_tag_pad;
    logic             in_trail;

    assign ofs_now = (sync_o && !sync_d) ? '0 : ofs_q;

    // Track the offset since sync rose and the lengths of the high and low runs
    always_ff @(posedge clk_bit) begin
        if (!rst_n) begin
            sync_d    <= 1'b0;
            started   <= 1'b0;
            seen_fall <= 1'b0;
            ofs_q     <= '0;
            hi_run    <= '0;
            lo_run    <= '0;
        end else begin
            sync_d    <= sync_o;
            started   <= started | (sync_o && !sync_d);
            seen_fall <= seen_fall | (!sync_o && sync_d);
            ofs_q     <= ofs_now + 1'b1;
            hi_run    <= sync_o ? hi_run + 1'b1 : '0;
            lo_run    <= sync_o ? '0 : lo_run + 1'b1;
        end
    end

    // Unused tag positions sit at offsets SLOTS+2..TAG_W, trailing slot bits after that
    always_comb begin
        in_tag_pad = started && (int'(ofs_now) >= SLOTS + 2) && (int'(ofs_now) <= TAG_W);
        in_trail   = started && (int'(ofs_now) >= TAG_W + 1) && (int'(ofs_now) < FRAME_LEN)
                     && (((int'(ofs_now) - TAG_W - 1) % SLOT_W) >= DATA_W);
    end

    p_rst_quiet_r1: assert property (@(posedge clk_bit)
        !rst_n |=> (!sync_o && !sdo_o && !frame_ld_o));

    p_sync_high_len_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $fell(sync_o) |-> (hi_run == CNT_W'(TAG_W)));

    p_sync_low_len_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
        ($rose(sync_o) && seen_fall) |-> (lo_run == CNT_W'(FRAME_LEN - TAG_W)));

    p_ld_on_rise_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        frame_ld_o |-> $rose(sync_o));

    p_rise_has_ld_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(sync_o) |-> frame_ld_o);

    p_tag_pad_zero_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
        in_tag_pad |-> !sdo_o);

    p_slot_trail_zero_r8: assert property (@(posedge clk_bit) disable iff (!rst_n)
        in_trail |-> !sdo_o);
endmodule

bind acl_link_tx acl_link_tx_chk #(
    .SLOTS (SLOTS),
    .SLOT_W(SLOT_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk_bit   (clk_bit),
    .rst_n     (rst_n),
    .sync_o    (sync_o),
    .sdo_o     (sdo_o),
    .frame_ld_o(frame_ld_o)
);

// File: tb/acl_link_tx_test.sv
`timescale 1ns/1ps
module acl_link_tx_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  slot_vld_i = '0;
    logic         cmd_rd_i = 1'b0;
    logic [6:0]   cmd_addr_i = '0;
    logic [15:0]  cmd_wdata_i = '0;
    logic [159:0] pcm_i = '0;
    logic         sync_o, sdo_o, frame_ld_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    acl_link_tx uut (
        .clk_bit(clk), .rst_n(rst_n), .slot_vld_i(slot_vld_i), .cmd_rd_i(cmd_rd_i),
        .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i), .pcm_i(pcm_i),
        .sync_o(sync_o), .sdo_o(sdo_o), .frame_ld_o(frame_ld_o)
    );

    // {mask[12], rd, addr[7], wdata[16], sample seed[16]}
    localparam logic [51:0] VECS [6] = '{
        {12'h000, 1'b1, 7'h3A, 16'hBEEF, 16'hFFFF},
        {12'hFFF, 1'b1, 7'h7E, 16'hFFFF, 16'h8001},
        {12'h001, 1'b0, 7'h02, 16'hA5C3, 16'h0000},
        {12'h800, 1'b0, 7'h00, 16'h0000, 16'hC3A5},
        {12'h555, 1'b1, 7'h40, 16'h1357, 16'h2468},
        {12'hAAA, 1'b0, 7'h14, 16'h8000, 16'h7FFF}
    };

    function automatic logic [15:0] samp(input logic [15:0] seed, input int s);
        return seed + 16'(s) * 16'h1357;
    endfunction

    // Slot word as the requirements define it
    function automatic logic [19:0] slot_word(input logic [51:0] v, input int s);
        if (!v[40 + s - 1]) return '0;
        if (s == 1) return {v[39], v[38:32], 12'h000};
        if (s == 2) return {v[31:16], 4'h0};
        return {samp(v[15:0], s), 4'h0};
    endfunction

    function automatic logic [15:0] tag_word(input logic [51:0] v);
        logic [15:0] t = '0;
        t[15] = |v[51:40];
        for (int s = 1; s <= 12; s++) t[15 - s] = v[40 + s - 1];
        return t;
    endfunction

    function automatic logic [255:0] exp_frame(input logic [51:0] v);
        logic [255:0] e = '0;
        logic [15:0] t = tag_word(v);
        for (int k = 0; k < 16; k++) e[k] = t[15 - k];
        for (int s = 1; s <= 12; s++) begin
            logic [19:0] w = slot_word(v, s);
            for (int b = 0; b < 20; b++) e[16 + (s - 1) * 20 + b] = w[19 - b];
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [51:0] v);
        slot_vld_i  = v[51:40];
        cmd_rd_i    = v[39];
        cmd_addr_i  = v[38:32];
        cmd_wdata_i = v[31:16];
        for (int s = 3; s <= 12; s++) pcm_i[(s - 3) * 16 +: 16] = samp(v[15:0], s);
    endtask

    task automatic scramble();
        slot_vld_i  = ~slot_vld_i;
        cmd_rd_i    = ~cmd_rd_i;
        cmd_addr_i  = ~cmd_addr_i;
        cmd_wdata_i = ~cmd_wdata_i;
        pcm_i       = ~pcm_i;
    endtask

    task automatic wait_ld();
        do @(negedge clk); while (!frame_ld_o);
    endtask

    // Called at the negedge of the sync-rise cycle; records and checks one frame
    task automatic grab_check(input logic [51:0] v, input string tag);
        logic [255:0] got = '0;
        logic [255:0] exp = exp_frame(v);
        int bad_sync = 0, bad_ld = 0;
        logic pre = sdo_o;
        scramble();
        for (int k = 1; k <= 256; k++) begin
            @(negedge clk);
            got[k - 1] = sdo_o;
            if (sync_o !== ((k < 16) || (k == 256))) bad_sync++;
            if (frame_ld_o !== (k == 256)) bad_ld++;
        end
        check(bad_sync == 0, {"R2 sync shape ", tag}, 256'(bad_sync), 0);
        check(bad_ld == 0, {"R3 strobe position ", tag}, 256'(bad_ld), 0);
        check(pre == 1'b0 && got[0] == exp[0], {"R4 first tag bit ", tag},
              {pre, got[0]}, {1'b0, exp[0]});
        check(got[15:0] == exp[15:0], {"R5 tag word ", tag}, got[15:0], exp[15:0]);
        for (int s = 1; s <= 12; s++) begin
            logic [19:0] a = got[16 + (s - 1) * 20 +: 20];
            logic [19:0] e = exp[16 + (s - 1) * 20 +: 20];
            string r = !v[40 + s - 1] ? "R9" : (s == 1) ? "R6" : (s == 2) ? "R7" : "R8";
            check(a == e, $sformatf("%s slot %0d %s", r, s, tag), a, e);
        end
        check(got == exp, {"R3 frame ignores late input changes ", tag}, got, exp);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        apply(VECS[1]);
        repeat (4) @(negedge clk);
        check(!sync_o && !sdo_o && !frame_ld_o, "R1 outputs low in reset",
              {sync_o, sdo_o, frame_ld_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sync_o && frame_ld_o, "R1 frame starts at first edge after reset",
              {sync_o, frame_ld_o}, 2'b11);
        grab_check(VECS[1], "after reset");

        for (int i = 0; i < 6; i++) begin
            apply(VECS[i]);
            wait_ld();
            grab_check(VECS[i], $sformatf("vector %0d", i));
        end

        // Reset in the data phase, then restart
        apply(VECS[4]);
        wait_ld();
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!sync_o && !sdo_o && !frame_ld_o, "R1 outputs low in mid-frame reset",
              {sync_o, sdo_o, frame_ld_o}, 0);
        apply(VECS[5]);
        rst_n = 1'b1;
        @(negedge clk);
        check(sync_o && frame_ld_o, "R1 restart after mid-frame reset",
              {sync_o, frame_ld_o}, 2'b11);
        grab_check(VECS[5], "after mid-frame reset");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule